// File: doc/BRIEF.md
# Sprite Attribute DMA Engine

This block copies a fixed run of 160 bytes from the system bus into sprite attribute RAM. A CPU write supplies an 8-bit source page. The engine reads from the base address formed by that page with a zero low byte, and writes to sprite RAM starting at index 0. The block has a bus-master read port of its own, so its reads do not pass through the CPU access path. It also has a write port into sprite RAM. It exports a busy flag, which the address decoder uses to lock the CPU out of the busy regions, and it exports the current source address.

The first byte moves a fixed start delay after the trigger. After that, one byte moves every four cycles. A page above 0xF1 is dropped without any effect. A valid trigger that arrives while a copy is running abandons the step that was pending and starts again from the beginning. A one-cycle done pulse marks the end of a copy.

Top module: `oam_dma_engine`

## Requirements
- R1: While rst_ni is low, and at the first sample after it is released, busy_o, done_o, rd_en_o and oam_we_o are 0 and src_addr_o is 0.
- R2: A trigger whose page is above 0xF1 is ignored. When it arrives while idle, busy_o stays 0 and no write occurs. When it arrives during a copy, the copy's write timing, indices and data are unchanged. Page 0xF1 itself is accepted.
- R3: Take edge k as the clock edge that samples an accepted trigger. After edge k, busy_o is 1, src_addr_o equals the page times 256, and the sprite-RAM index restarts at 0.
- R4: The first write strobe (oam_we_o) is high in the cycle that ends at edge k+8. It is low in every earlier cycle after edge k.
- R5: Write n (counting from 0) is strobed in the cycle that ends at edge k+8+4n. In the three cycles between two writes, oam_we_o is low.
- R6: During each write strobe, rd_en_o is 1, rd_addr_o is the base plus n, oam_addr_o is n, and oam_wdata_o equals rd_data_i. After the strobe, the source address and the index each advance by one.
- R7: busy_o stays high until exactly 160 writes have been made. It falls at edge k+644, and no further write follows.
- R8: done_o is high for exactly the one cycle after edge k+644, together with busy_o falling. It is 0 at all other times.
- R9: An accepted trigger during a copy restarts the copy. The new page, index 0 and the full 8-cycle start delay all apply again, counted from the new trigger.
- R10: If an accepted trigger arrives in the same cycle as a due write, that write is cancelled. oam_we_o and rd_en_o are 0 in that cycle.
- R11: An asynchronous reset in the middle of a copy clears busy_o at once, and no further write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | One-cycle trigger strobe from the CPU register write |
| trig_page_i | input | 8 | Source page supplied with the trigger |
| busy_o | output | 1 | Copy in progress, used by the decoder lockout |
| src_addr_o | output | 16 | Current source address |
| rd_en_o | output | 1 | Bus-master read strobe |
| rd_addr_o | output | 16 | Bus-master read address |
| rd_data_i | input | 8 | Bus-master read data, valid in the strobe cycle |
| oam_we_o | output | 1 | Sprite RAM write strobe |
| oam_addr_o | output | 8 | Sprite RAM write index |
| oam_wdata_o | output | 8 | Sprite RAM write data |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two functions can fall in the same cycle: a fresh trigger, and a transfer slot that is already due. To provoke this, the bench lets a copy run until its fourth slot and raises a valid trigger in exactly that cycle. The cycle is judged at the ports. The write and read strobes must be low in that cycle. The copy that follows must start at index 0 from the new page, with its first strobe eight cycles later. An out-of-range trigger placed inside a running copy is judged the same way: the strobe pattern and the data must be exactly those of an undisturbed copy.

// File: rtl/oam_dma_pkg.sv
package oam_dma_pkg;
  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned cnt_w(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v);
  endfunction
endpackage

// File: rtl/oam_dma_trig.sv
module oam_dma_trig #(
  parameter int unsigned PAGE_W   = 8,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned PAGE_MAX = 8'hF1
) (
  input  logic              valid_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic              accept_o,
  output logic [ADDR_W-1:0] base_o
);
  localparam int unsigned LOW_W = ADDR_W - PAGE_W;

  assign accept_o = valid_i && (page_i <= PAGE_W'(PAGE_MAX));
  assign base_o   = {page_i, {LOW_W{1'b0}}};
endmodule

// File: rtl/oam_dma_pacer.sv
module oam_dma_pacer
  import oam_dma_pkg::*;
#(
  parameter int unsigned START_DLY = 8,
  parameter int unsigned STEP_DLY  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic active_i,
  output logic slot_o
);
  localparam int unsigned CW = cnt_w(max2(START_DLY, STEP_DLY));
  localparam logic [CW-1:0] START_LD = CW'(START_DLY - 1);
  localparam logic [CW-1:0] STEP_LD  = CW'(STEP_DLY - 1);

  logic [CW-1:0] wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          wait_q <= '0;
    else if (restart_i)   wait_q <= START_LD;
    else if (active_i) begin
      if (wait_q == '0)   wait_q <= STEP_LD;
      else                wait_q <= wait_q - 1'b1;
    end
  end

  assign slot_o = active_i && (wait_q == '0);

  assert_start_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !slot_o);
  assert_step_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_o && !restart_i) |=> !slot_o);
endmodule

// File: rtl/oam_dma_cursor.sv
module oam_dma_cursor
  import oam_dma_pkg::*;
#(
  parameter int unsigned XFER_LEN = 160,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned IDX_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] src_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int unsigned RW = cnt_w(XFER_LEN + 1);
  localparam logic [RW-1:0] LEN = RW'(XFER_LEN);

  logic [ADDR_W-1:0] src_q;
  logic [IDX_W-1:0]  idx_q;
  logic [RW-1:0]     rem_q;
  logic              done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      idx_q  <= '0;
      rem_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (restart_i) begin
        src_q <= base_i;
        idx_q <= '0;
        rem_q <= LEN;
      end else if (step_i) begin
        src_q  <= src_q + 1'b1;
        idx_q  <= idx_q + 1'b1;
        rem_q  <= rem_q - 1'b1;
        done_q <= (rem_q == RW'(1));
      end
    end
  end

  assign src_o  = src_q;
  assign idx_o  = idx_q;
  assign busy_o = (rem_q != '0);
  assign done_o = done_q;

  assert_step_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> busy_o);
  assert_src_adv_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !restart_i) |=> (src_o == $past(src_o) + 1'b1) && (idx_o == $past(idx_o) + 1'b1));
  assert_done_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/oam_dma_engine.sv
module oam_dma_engine #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PAGE_W    = 8,
  parameter int unsigned OAM_AW    = 8,
  parameter int unsigned XFER_LEN  = 160,
  parameter int unsigned START_DLY = 8,
  parameter int unsigned STEP_DLY  = 4,
  parameter int unsigned PAGE_MAX  = 8'hF1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic [PAGE_W-1:0] trig_page_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              oam_we_o,
  output logic [OAM_AW-1:0] oam_addr_o,
  output logic [DATA_W-1:0] oam_wdata_o,
  output logic              done_o
);
  logic              accept;
  logic [ADDR_W-1:0] base;
  logic              slot;
  logic              xfer;
  logic              busy;
  logic [ADDR_W-1:0] src;
  logic [OAM_AW-1:0] idx;

  oam_dma_trig #(
    .PAGE_W(PAGE_W), .ADDR_W(ADDR_W), .PAGE_MAX(PAGE_MAX)
  ) u_trig (
    .valid_i(trig_i), .page_i(trig_page_i), .accept_o(accept), .base_o(base)
  );

  oam_dma_pacer #(
    .START_DLY(START_DLY), .STEP_DLY(STEP_DLY)
  ) u_pacer (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(accept), .active_i(busy), .slot_o(slot)
  );

  // a restart cancels a slot falling in the same cycle
  assign xfer = slot && !accept;

  oam_dma_cursor #(
    .XFER_LEN(XFER_LEN), .ADDR_W(ADDR_W), .IDX_W(OAM_AW)
  ) u_cursor (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(accept), .base_i(base), .step_i(xfer),
    .src_o(src), .idx_o(idx), .busy_o(busy), .done_o(done_o)
  );

  // dedicated master port: not gated by the decoder lockout
  assign rd_en_o     = xfer;
  assign rd_addr_o   = src;
  assign oam_we_o    = xfer;
  assign oam_addr_o  = idx;
  assign oam_wdata_o = rd_data_i;
  assign busy_o      = busy;
  assign src_addr_o  = src;

  assert_bad_page_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && (trig_page_i > PAGE_W'(PAGE_MAX)) && !busy_o) |=> !busy_o);
  assert_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_o && (oam_addr_o == '0) && (src_addr_o == $past(base)));
  assert_restart_cancel_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && (trig_page_i <= PAGE_W'(PAGE_MAX))) |-> !oam_we_o);
endmodule

// File: tb/tb_oam_dma_engine.sv
module tb_oam_dma_engine;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        trig_i = 1'b0;
  logic [7:0]  trig_page_i = '0;
  logic        busy_o, rd_en_o, oam_we_o, done_o;
  logic [15:0] src_addr_o, rd_addr_o;
  logic [7:0]  rd_data_i, oam_addr_o, oam_wdata_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #10 clk_i = ~clk_i;

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction
  assign rd_data_i = mem_f(rd_addr_o);

  oam_dma_engine dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig_i), .trig_page_i(trig_page_i),
    .busy_o(busy_o), .src_addr_o(src_addr_o), .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o),
    .rd_data_i(rd_data_i), .oam_we_o(oam_we_o), .oam_addr_o(oam_addr_o),
    .oam_wdata_o(oam_wdata_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // follows cycles j_first..j_last after the edge that sampled the trigger
  task automatic follow(input logic [7:0] page, input int j_first, input int j_last);
    for (int j = j_first; j <= j_last; j++) begin
      @(negedge clk_i);
      trig_i = 1'b0;
      #1;
      begin
        logic [15:0] base;
        bit slot;
        int n;
        base = {page, 8'h00};
        n    = (j - 8) / 4;
        slot = (j >= 8) && ((j - 8) % 4 == 0) && (n < 160);
        if (j == 1) chk(src_addr_o == base && oam_addr_o == 0, "R3 load", src_addr_o, base);
        if (j < 8)  chk(!oam_we_o, "R4 early", oam_we_o, 0);
        else        chk(oam_we_o == slot, "R5 cadence", oam_we_o, slot);
        if (slot) begin
          chk(rd_en_o && rd_addr_o == base + 16'(n), "R6 read", rd_addr_o, base + 16'(n));
          chk(oam_addr_o == 8'(n), "R6 index", oam_addr_o, n);
          chk(oam_wdata_o == mem_f(base + 16'(n)), "R6 data", oam_wdata_o, mem_f(base + 16'(n)));
        end
        chk(busy_o == (j <= 644), "R7 busy", busy_o, (j <= 644));
        chk(done_o == (j == 645), "R8 done", done_o, (j == 645));
      end
    end
  endtask

  task automatic fire(input logic [7:0] page);
    @(negedge clk_i);
    trig_i = 1'b1;
    trig_page_i = page;
  endtask

  localparam logic [8:0] VEC [6] = '{
    {8'h00, 1'b1}, {8'h80, 1'b1}, {8'hF1, 1'b1},
    {8'hF2, 1'b0}, {8'hFF, 1'b0}, {8'hC3, 1'b1}
  };

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!ended) begin
      ended = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    chk(!busy_o && !done_o && !oam_we_o && !rd_en_o && src_addr_o == 0, "R1 in reset", busy_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    chk(!busy_o && !done_o && !oam_we_o && src_addr_o == 0, "R1 after reset", busy_o, 0);

    foreach (VEC[i]) begin
      fire(VEC[i][8:1]);
      if (VEC[i][0]) follow(VEC[i][8:1], 1, 646);
      else begin
        for (int j = 1; j <= 12; j++) begin
          @(negedge clk_i);
          trig_i = 1'b0;
          #1;
          chk(!busy_o && !oam_we_o, "R2 idle ignore", busy_o, 0);
        end
      end
    end

    // R2: out-of-range trigger during a copy leaves it undisturbed
    fire(8'h12);
    follow(8'h12, 1, 9);
    @(negedge clk_i);
    trig_i = 1'b1;
    trig_page_i = 8'hF7;
    #1;
    chk(busy_o && !oam_we_o, "R2 busy ignore", busy_o, 1);
    follow(8'h12, 11, 646);

    // R9: restart on a non-slot cycle
    fire(8'h34);
    follow(8'h34, 1, 10);
    fire(8'h56);
    follow(8'h56, 1, 646);

    // R10: restart coinciding with the fourth slot (cycle 20)
    fire(8'h78);
    follow(8'h78, 1, 19);
    @(negedge clk_i);
    trig_i = 1'b1;
    trig_page_i = 8'h9A;
    #1;
    chk(!oam_we_o && !rd_en_o, "R10 cancel", oam_we_o, 0);
    follow(8'h9A, 1, 646);

    // R11: reset mid-copy
    fire(8'h21);
    follow(8'h21, 1, 30);
    rst_ni = 1'b0;
    #1;
    chk(!busy_o && !oam_we_o, "R11 reset busy", busy_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int j = 0; j < 12; j++) begin
      @(negedge clk_i);
      #1;
      chk(!busy_o && !oam_we_o && !done_o, "R11 quiet", oam_we_o, 0);
    end

    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule